// File: doc/BRIEF.md
# Dual-Converter Channel Scan Sequencer

This block is the digital control for two successive-approximation converters that always sample together. Each converter has an eight-input multiplexer. Software, or a hardware trigger, starts a scan. The sequencer then works through the enabled multiplexer channels without any software help between channels. For each channel it drives the select lines and the single-ended or differential setting. It holds a sample phase whose length can be extended. It then runs a bit-serial search against each converter's comparator, one bit per clock and most significant bit first.

The comparator and the trial-code reference are outside the block. The block presents a trial code on `dac_code`, and the comparator reports whether the sampled input is at or above that code. The block keeps one result per converter and channel, and it pulses an interrupt when the whole scan has finished. Both converters share one channel index. A channel is visited when either converter has it enabled, and a converter stores a result only for the channels in its own mask.

Top module: `adc_scan_seq`

## Requirements
- R1: After reset, `busy`, `irq`, `overrun` and `sample_hold` are low and every stored result is zero.
- R2: A high `sw_start` or `hw_trig` while idle starts a scan. The masks, differential bits, resolution and sample extension are captured at that edge, and later changes to them have no effect until the next scan.
- R3: Channel indices are visited in ascending order. An index is visited when its bit is set in either converter's mask (bit i of converter c sits at `cfg_mask[c*8+i]`), and all other indices are skipped. `mux_sel` carries the index to both multiplexers.
- R4: Each visit begins with a sample phase. During it, `sample_hold` stays high for exactly `cfg_ext`+1 cycles, and both converters sample in those same cycles.
- R5: After the sample phase comes a search of N cycles. In the first cycle the trial code is 0x800. Each later trial is the bits kept so far plus the next lower bit. A bit is kept when its `cmp_in` bit is 1. Outside the search, `dac_code` is zero.
- R6: `cfg_res` codes 0, 1, 2, 3 give N = 6, 8, 10, 12. A result holds the N kept bits in the top of a 12-bit word, with the low 12-N bits zero. A whole scan of K visited channels keeps `busy` high for K*(`cfg_ext`+1+N) cycles.
- R7: A converter whose mask bit is clear at a visited index leaves its stored result for that index unchanged.
- R8: `irq` pulses high for one cycle, with `busy` low, right after the last search step. A scan with all mask bits clear pulses `irq` in the cycle after the start, with no sample phase.
- R9: A trigger that arrives while busy is ignored, and it sets the sticky `overrun`. `overrun` clears only on `ovr_clr`, and a trigger in the same cycle wins over the clear.
- R10: During a visit, `mux_diff[c]` equals the captured differential bit of converter c for the current index (`cfg_diff[c*8+i]`, where 1 means differential).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sw_start | input | 1 | Software scan start |
| hw_trig | input | 1 | Hardware scan trigger |
| ovr_clr | input | 1 | Clears the overrun flag |
| cfg_mask | input | NCONV*NCH | Per-converter channel enable masks |
| cfg_diff | input | NCONV*NCH | Per-converter differential selects |
| cfg_res | input | 2 | Resolution code |
| cfg_ext | input | EXT_W | Extra sample cycles |
| cmp_in | input | NCONV | Comparator outputs, 1 when the input is at or above the trial code |
| mux_sel | output | log2(NCH) | Channel index for both multiplexers |
| mux_diff | output | NCONV | Differential setting per converter |
| sample_hold | output | 1 | High during the sample phase |
| dac_code | output | NCONV*RES_MAX | Trial code per converter |
| results | output | NCONV*NCH*RES_MAX | Stored results, left-aligned, converter-major |
| busy | output | 1 | Scan in progress |
| irq | output | 1 | One-cycle scan-complete pulse |
| overrun | output | 1 | Sticky flag for a trigger that arrived while busy |

## Verification
The bench builds the block with its default parameters: two converters, eight channels, a 12-bit maximum resolution and a 4-bit sample extension. It sweeps every resolution code against the extensions 0, 1, 5 and 15, and it runs each pairing with six mask pairs. Those pairs include full, one-sided, disjoint and single-bit masks, so the skipping of channels, the stores for only one converter and the longest scan all come up. The comparator model works out each result arithmetically from a per-channel input value. Full-scale and zero inputs are included. One scan changes the configuration and fires a trigger in mid-scan, and another scan has empty masks.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;
   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_SAMPLE = 2'd1,
      ST_CONV   = 2'd2
   } scan_state_t;
endpackage

// File: rtl/adc_scan_pick.sv
// Lowest set mask bit above (or, with incl, at) a starting index.
module adc_scan_pick #(
   parameter int NCH   = 8,
   parameter int IDX_W = 3
) (
   input  logic [NCH-1:0]   mask,
   input  logic [IDX_W-1:0] from,
   input  logic             incl,
   output logic [IDX_W-1:0] nxt,
   output logic             found
);
   always_comb begin
      found = 1'b0;
      nxt   = '0;
      for (int i = NCH - 1; i >= 0; i--) begin
         if (mask[i] && ((i > int'(from)) || (incl && (i == int'(from))))) begin
            found = 1'b1;
            nxt   = IDX_W'(i);
         end
      end
   end
endmodule

// File: rtl/adc_scan_ctrl.sv
// Scan state machine: channel stepping, sample timer, search step count.
module adc_scan_ctrl
   import adc_scan_pkg::*;
#(
   parameter int NCH     = 8,
   parameter int RES_MAX = 12,
   parameter int EXT_W   = 4,
   parameter int IDX_W   = 3,
   parameter int STEP_W  = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start_req,
   input  logic               ovr_clr,
   input  logic [NCH-1:0]     live_mask,
   input  logic [1:0]         res_in,
   input  logic [EXT_W-1:0]   ext_in,
   output logic               cap,
   output logic [IDX_W-1:0]   idx,
   output logic               sampling,
   output logic               converting,
   output logic [RES_MAX-1:0] bit_oh,
   output logic               last,
   output logic               busy,
   output logic               irq,
   output logic               overrun
);
   scan_state_t        state;
   logic [NCH-1:0]     union_q;
   logic [EXT_W-1:0]   ext_q;
   logic [EXT_W-1:0]   cnt;
   logic [STEP_W-1:0]  nbits_q;
   logic [STEP_W-1:0]  step;
   logic [IDX_W-1:0]   nxt;
   logic               found;
   logic               idle;

   assign idle       = (state == ST_IDLE);
   assign sampling   = (state == ST_SAMPLE);
   assign converting = (state == ST_CONV);
   assign busy       = !idle;
   assign cap        = idle && start_req;
   assign bit_oh     = {1'b1, {(RES_MAX-1){1'b0}}} >> step;
   assign last       = converting && ((step + STEP_W'(1)) == nbits_q);

   adc_scan_pick #(.NCH(NCH), .IDX_W(IDX_W)) i_pick (
      .mask  (idle ? live_mask : union_q),
      .from  (idle ? '0 : idx),
      .incl  (idle),
      .nxt   (nxt),
      .found (found)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         union_q <= '0;
         ext_q   <= '0;
         cnt     <= '0;
         nbits_q <= '0;
         step    <= '0;
         idx     <= '0;
         irq     <= 1'b0;
         overrun <= 1'b0;
      end else begin
         irq <= 1'b0;
         if (start_req && !idle)
            overrun <= 1'b1;
         else if (ovr_clr)
            overrun <= 1'b0;
         unique case (state)
            ST_IDLE: if (start_req) begin
               union_q <= live_mask;
               ext_q   <= ext_in;
               nbits_q <= STEP_W'(RES_MAX - 6) + STEP_W'({res_in, 1'b0});
               if (found) begin
                  state <= ST_SAMPLE;
                  idx   <= nxt;
                  cnt   <= ext_in;
               end else begin
                  irq <= 1'b1;
               end
            end
            ST_SAMPLE: begin
               if (cnt == '0) begin
                  state <= ST_CONV;
                  step  <= '0;
               end else begin
                  cnt <= cnt - EXT_W'(1);
               end
            end
            ST_CONV: begin
               if (last) begin
                  if (found) begin
                     state <= ST_SAMPLE;
                     idx   <= nxt;
                     cnt   <= ext_q;
                  end else begin
                     state <= ST_IDLE;
                     irq   <= 1'b1;
                  end
               end else begin
                  step <= step + STEP_W'(1);
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/adc_sar_lane.sv
// One converter: captured mask and differential bits, search register, result bank.
module adc_sar_lane #(
   parameter int NCH     = 8,
   parameter int RES_MAX = 12,
   parameter int IDX_W   = 3
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   cap,
   input  logic [NCH-1:0]         mask_in,
   input  logic [NCH-1:0]         diff_in,
   input  logic [IDX_W-1:0]       idx,
   input  logic                   sampling,
   input  logic                   converting,
   input  logic [RES_MAX-1:0]     bit_oh,
   input  logic                   last,
   input  logic                   cmp,
   output logic [RES_MAX-1:0]     dac_code,
   output logic                   diff,
   output logic [NCH*RES_MAX-1:0] res_flat
);
   logic [NCH-1:0]     mask_q;
   logic [NCH-1:0]     diff_q;
   logic [RES_MAX-1:0] acc;
   logic [RES_MAX-1:0] trial;
   logic [RES_MAX-1:0] kept;
   logic [RES_MAX-1:0] res_q [NCH];

   assign trial    = acc | bit_oh;
   assign kept     = cmp ? trial : acc;
   assign dac_code = converting ? trial : '0;
   assign diff     = diff_q[idx];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= '0;
         diff_q <= '0;
         acc    <= '0;
         for (int i = 0; i < NCH; i++) res_q[i] <= '0;
      end else begin
         if (cap) begin
            mask_q <= mask_in;
            diff_q <= diff_in;
         end
         if (sampling)
            acc <= '0;
         else if (converting)
            acc <= kept;
         if (last && mask_q[idx])
            res_q[idx] <= kept;
      end
   end

   for (genvar i = 0; i < NCH; i++) begin : g_res
      assign res_flat[i*RES_MAX +: RES_MAX] = res_q[i];
   end
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq #(
   parameter int NCONV   = 2,
   parameter int NCH     = 8,
   parameter int RES_MAX = 12,
   parameter int EXT_W   = 4
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         sw_start,
   input  logic                         hw_trig,
   input  logic                         ovr_clr,
   input  logic [NCONV*NCH-1:0]         cfg_mask,
   input  logic [NCONV*NCH-1:0]         cfg_diff,
   input  logic [1:0]                   cfg_res,
   input  logic [EXT_W-1:0]             cfg_ext,
   input  logic [NCONV-1:0]             cmp_in,
   output logic [$clog2(NCH)-1:0]       mux_sel,
   output logic [NCONV-1:0]             mux_diff,
   output logic                         sample_hold,
   output logic [NCONV*RES_MAX-1:0]     dac_code,
   output logic [NCONV*NCH*RES_MAX-1:0] results,
   output logic                         busy,
   output logic                         irq,
   output logic                         overrun
);
   localparam int IDX_W  = $clog2(NCH);
   localparam int STEP_W = $clog2(RES_MAX + 1);

   if (NCONV < 1) begin : g_bad_nconv
      $error("NCONV must be at least 1");
   end
   if (NCH < 2) begin : g_bad_nch
      $error("NCH must be at least 2");
   end
   if (RES_MAX < 8) begin : g_bad_res
      $error("RES_MAX must be at least 8");
   end
   if (EXT_W < 1) begin : g_bad_ext
      $error("EXT_W must be at least 1");
   end

   logic [NCH-1:0]     union_mask;
   logic               cap;
   logic               converting;
   logic               last;
   logic [RES_MAX-1:0] bit_oh;

   always_comb begin
      union_mask = '0;
      for (int c = 0; c < NCONV; c++)
         union_mask = union_mask | cfg_mask[c*NCH +: NCH];
   end

   adc_scan_ctrl #(
      .NCH(NCH), .RES_MAX(RES_MAX), .EXT_W(EXT_W), .IDX_W(IDX_W), .STEP_W(STEP_W)
   ) i_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_req  (sw_start | hw_trig),
      .ovr_clr    (ovr_clr),
      .live_mask  (union_mask),
      .res_in     (cfg_res),
      .ext_in     (cfg_ext),
      .cap        (cap),
      .idx        (mux_sel),
      .sampling   (sample_hold),
      .converting (converting),
      .bit_oh     (bit_oh),
      .last       (last),
      .busy       (busy),
      .irq        (irq),
      .overrun    (overrun)
   );

   for (genvar c = 0; c < NCONV; c++) begin : g_lane
      adc_sar_lane #(.NCH(NCH), .RES_MAX(RES_MAX), .IDX_W(IDX_W)) i_lane (
         .clk        (clk),
         .rst_n      (rst_n),
         .cap        (cap),
         .mask_in    (cfg_mask[c*NCH +: NCH]),
         .diff_in    (cfg_diff[c*NCH +: NCH]),
         .idx        (mux_sel),
         .sampling   (sample_hold),
         .converting (converting),
         .bit_oh     (bit_oh),
         .last       (last),
         .cmp        (cmp_in[c]),
         .dac_code   (dac_code[c*RES_MAX +: RES_MAX]),
         .diff       (mux_diff[c]),
         .res_flat   (results[c*NCH*RES_MAX +: NCH*RES_MAX])
      );
   end
endmodule

// File: rtl/adc_scan_chk.sv
module adc_scan_chk #(
   parameter int NCONV   = 2,
   parameter int RES_MAX = 12,
   parameter int IDX_W   = 3
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     sw_start,
   input logic                     hw_trig,
   input logic                     ovr_clr,
   input logic [IDX_W-1:0]         mux_sel,
   input logic                     sample_hold,
   input logic [NCONV*RES_MAX-1:0] dac_code,
   input logic                     busy,
   input logic                     irq,
   input logic                     overrun
);
   AST_RESET_QUIET: assert property (@(posedge clk) $rose(rst_n) |-> (!busy && !irq && !overrun && !sample_hold)); // R1
   AST_SEL_HELD: assert property (@(posedge clk) disable iff (!rst_n) (sample_hold && $past(sample_hold)) |-> $stable(mux_sel)); // R3
   AST_NO_TRIAL_IN_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n) sample_hold |-> (dac_code == '0)); // R5
   AST_IRQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n) irq |-> !busy); // R8
   AST_OVR_SET: assert property (@(posedge clk) disable iff (!rst_n) (busy && (sw_start || hw_trig)) |=> overrun); // R9
   AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (overrun && !ovr_clr) |=> overrun); // R9

   for (genvar c = 0; c < NCONV; c++) begin : g_msb
      AST_MSB_FIRST: assert property (@(posedge clk) disable iff (!rst_n) ($fell(sample_hold) && busy) |-> (dac_code[c*RES_MAX +: RES_MAX] == {1'b1, {(RES_MAX-1){1'b0}}})); // R5
   end
endmodule

bind adc_scan_seq adc_scan_chk #(.NCONV(NCONV), .RES_MAX(RES_MAX), .IDX_W(IDX_W)) i_chk (
   .clk(clk), .rst_n(rst_n), .sw_start(sw_start), .hw_trig(hw_trig), .ovr_clr(ovr_clr),
   .mux_sel(mux_sel), .sample_hold(sample_hold), .dac_code(dac_code),
   .busy(busy), .irq(irq), .overrun(overrun)
);

// File: tb/test_adc_scan_seq.sv
module test_adc_scan_seq;
   localparam int CLK_PERIOD = 10;
   localparam int NCONV = 2;
   localparam int NCH   = 8;
   localparam int RMAX  = 12;
   localparam int EXT_W = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sw_start = 1'b0, hw_trig = 1'b0, ovr_clr = 1'b0;
   logic [NCONV*NCH-1:0] cfg_mask = '0, cfg_diff = '0;
   logic [1:0] cfg_res = '0;
   logic [EXT_W-1:0] cfg_ext = '0;
   logic [NCONV-1:0] cmp_in;
   logic [2:0] mux_sel;
   logic [NCONV-1:0] mux_diff;
   logic sample_hold, busy, irq, overrun;
   logic [NCONV*RMAX-1:0] dac_code;
   logic [NCONV*NCH*RMAX-1:0] results;

   logic [RMAX-1:0] vin [NCONV][NCH];
   logic [RMAX-1:0] exp_res [NCONV][NCH];

   int nchk = 0, nfail = 0;
   int busy_cnt, irq_cnt, samp_err, msb_err, diff_err, run_len, nvis;
   int exp_run;
   logic [NCONV*NCH-1:0] exp_diff;
   logic prev_sh = 1'b0;
   int visits [64];

   always #(CLK_PERIOD/2) clk = ~clk;

   for (genvar c = 0; c < NCONV; c++) begin : g_cmp
      assign cmp_in[c] = vin[c][mux_sel] >= dac_code[c*RMAX +: RMAX];
   end

   adc_scan_seq #(.NCONV(NCONV), .NCH(NCH), .RES_MAX(RMAX), .EXT_W(EXT_W)) i_adc_scan_seq (
      .clk(clk), .rst_n(rst_n), .sw_start(sw_start), .hw_trig(hw_trig), .ovr_clr(ovr_clr),
      .cfg_mask(cfg_mask), .cfg_diff(cfg_diff), .cfg_res(cfg_res), .cfg_ext(cfg_ext),
      .cmp_in(cmp_in), .mux_sel(mux_sel), .mux_diff(mux_diff), .sample_hold(sample_hold),
      .dac_code(dac_code), .results(results), .busy(busy), .irq(irq), .overrun(overrun)
   );

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
   endtask

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // Monitor, sampled at the falling edge
   always @(negedge clk) begin
      if (busy) busy_cnt++;
      if (irq) irq_cnt++;
      if (sample_hold) begin
         if (!prev_sh) begin
            if (nvis < 64) visits[nvis] = int'(mux_sel);
            nvis++;
            run_len = 1;
         end else begin
            run_len++;
         end
         for (int c = 0; c < NCONV; c++)
            if (mux_diff[c] !== exp_diff[c*NCH + int'(mux_sel)]) diff_err++;
      end else if (prev_sh) begin
         if (run_len != exp_run) samp_err++;
         for (int c = 0; c < NCONV; c++)
            if (dac_code[c*RMAX +: RMAX] !== 12'h800) msb_err++;
      end
      prev_sh = sample_hold;
   end

   // Hard watchdog
   initial begin
      repeat (190000) @(posedge clk);
      chk(1'b0, "WDOG", "watchdog expired", 0, 1);
      summary();
      $finish;
   end

   task automatic run_scan(input logic [7:0] m0, input logic [7:0] m1, input logic [15:0] dif,
                           input int res, input int ext, input bit use_hw, input bit tweak, input int seed);
      int n, k, t, bad, skip_bad, ve;
      logic [RMAX-1:0] lmask;
      logic [7:0] un;
      n = 6 + 2*res;
      un = m0 | m1;
      k = $countones(un);
      lmask = 12'hFFF << (RMAX - n);
      for (int c = 0; c < NCONV; c++)
         for (int ch = 0; ch < NCH; ch++) begin
            if (seed == 0) vin[c][ch] = (c == 0) ? 12'hFFF : 12'h000;
            else vin[c][ch] = 12'((c*1234 + ch*517 + seed*97 + 5) % 4096);
         end
      @(negedge clk);
      cfg_mask = {m1, m0};
      cfg_diff = dif;
      cfg_res = 2'(res);
      cfg_ext = EXT_W'(ext);
      exp_diff = dif;
      exp_run = ext + 1;
      busy_cnt = 0; irq_cnt = 0; samp_err = 0; msb_err = 0; diff_err = 0; nvis = 0;
      if (use_hw) hw_trig = 1'b1; else sw_start = 1'b1;
      @(negedge clk);
      hw_trig = 1'b0; sw_start = 1'b0;
      if (tweak) begin
         repeat (3) @(negedge clk);
         hw_trig = 1'b1;                 // ignored trigger while busy (R9)
         cfg_mask = ~cfg_mask;           // config changes mid-scan (R2)
         cfg_res = ~cfg_res;
         cfg_ext = ~cfg_ext;
         cfg_diff = ~cfg_diff;
         @(negedge clk);
         hw_trig = 1'b0;
      end
      t = 0;
      while (irq_cnt == 0 && t < 4000) begin @(negedge clk); t++; end
      repeat (2) @(negedge clk);
      chk(t < 4000, "R8", "scan completion seen", t, 0);
      chk(irq_cnt == 1, "R8", "irq pulse count", irq_cnt, 1);
      chk(busy_cnt == k*(ext + 1 + n), "R6", "busy cycles", busy_cnt, k*(ext + 1 + n));
      chk(nvis == k, "R3", "visit count", nvis, k);
      bad = 0; ve = 0;
      for (int i = 0; i < NCH; i++)
         if (un[i]) begin
            if (ve < 64 && visits[ve] != i) bad++;
            ve++;
         end
      chk(bad == 0, "R3", "ascending visit order mismatches", bad, 0);
      chk(samp_err == 0, "R4", "sample phase length errors", samp_err, 0);
      chk(msb_err == 0, "R5", "first trial code errors", msb_err, 0);
      chk(diff_err == 0, "R10", "differential select errors", diff_err, 0);
      bad = 0; skip_bad = 0;
      for (int c = 0; c < NCONV; c++)
         for (int ch = 0; ch < NCH; ch++) begin
            logic en;
            en = (c == 0) ? m0[ch] : m1[ch];
            if (en) exp_res[c][ch] = vin[c][ch] & lmask;
            if (results[(c*NCH + ch)*RMAX +: RMAX] !== exp_res[c][ch]) begin
               if (en) bad++; else skip_bad++;
            end
         end
      chk(bad == 0, "R6", "result mismatches", bad, 0);
      chk(skip_bad == 0, "R7", "unselected result changed", skip_bad, 0);
      if (tweak) begin
         chk(overrun == 1'b1, "R9", "overrun after busy trigger", int'(overrun), 1);
         @(negedge clk); ovr_clr = 1'b1;
         @(negedge clk); ovr_clr = 1'b0;
         chk(overrun == 1'b0, "R9", "overrun cleared", int'(overrun), 0);
      end
   endtask

   initial begin
      logic [7:0] pm0 [6];
      logic [7:0] pm1 [6];
      int exts [4];
      int rbad;
      pm0 = '{8'hFF, 8'h81, 8'h00, 8'hA5, 8'h01, 8'h10};
      pm1 = '{8'hFF, 8'h00, 8'h5A, 8'h3C, 8'h80, 8'h10};
      exts = '{0, 1, 5, 15};
      for (int c = 0; c < NCONV; c++)
         for (int ch = 0; ch < NCH; ch++) begin
            vin[c][ch] = '0;
            exp_res[c][ch] = '0;
         end
      exp_diff = '0; exp_run = 1;
      busy_cnt = 0; irq_cnt = 0; samp_err = 0; msb_err = 0; diff_err = 0; run_len = 0; nvis = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(!busy && !irq && !overrun && !sample_hold, "R1", "idle outputs after reset",
          int'({busy, irq, overrun, sample_hold}), 0);
      rbad = 0;
      for (int i = 0; i < NCONV*NCH; i++) if (results[i*RMAX +: RMAX] !== '0) rbad++;
      chk(rbad == 0, "R1", "results zero after reset", rbad, 0);

      // Empty masks: immediate completion (R8)
      run_scan(8'h00, 8'h00, 16'h0, 3, 2, 1'b0, 1'b0, 1);
      chk(overrun == 1'b0, "R9", "no overrun without busy trigger", int'(overrun), 0);

      // Sweep resolution x extension x masks (R3..R7, R10), both start paths (R2)
      for (int r = 0; r < 4; r++)
         for (int e = 0; e < 4; e++)
            for (int p = 0; p < 6; p++)
               run_scan(pm0[p], pm1[p], {pm1[p] ^ 8'h33, pm0[p] ^ 8'hC6}, r, exts[e],
                        bit'((r + e + p) % 2), 1'b0, (p == 0 && e == 0) ? 0 : r*31 + e*7 + p);

      // Mid-scan config change and ignored trigger (R2, R9)
      run_scan(8'h6B, 8'h94, 16'h5AA5, 1, 3, 1'b0, 1'b1, 77);
      run_scan(8'h0F, 8'hF0, 16'h0FF0, 2, 0, 1'b1, 1'b1, 91);

      summary();
      $finish;
   end
endmodule